// File: doc/BRIEF.md
# Video Controller Register Write Port with Auto-Indexed Palette

This block is the write side of a video controller's control registers. A host issues 32-bit write words: the top byte selects a target and the low 24 bits carry the value. Ordinary targets (border colour, three cursor colours, six horizontal and eight vertical timing values, and four control words for external signals, clock synthesis, general control and data control) are captured in a shadow store. That store can be read back one cycle after a read selector is applied.

The 256-entry colour lookup table has no address of its own on the write side. One selector rewinds a hidden pointer to entry zero. A second selector deposits its payload at the pointer and advances it, wrapping past the last entry. A write whose selector names no target changes nothing. It raises a one-cycle reject pulse and sets a sticky error bit, which stays set until a dedicated clear input is applied.

Top module: `vreg_port`

## Requirements
- R1: The selector is wr_word[31:24] and the payload is wr_word[23:0]. A write with an ordinary selector stores the payload in that register. Applying the same code on rd_sel returns the stored value on rd_shadow one cycle later. The ordinary codes are 8'h10 (border), 8'h11 to 8'h13 (cursor colours), 8'h20 to 8'h25 (horizontal timing), 8'h30 to 8'h37 (vertical timing) and 8'h40 to 8'h43 (external, synthesiser, control, data control).
- R2: A write with selector 8'h00 sets the palette pointer to 0, whatever its payload.
- R3: A write with selector 8'h01 stores the payload at the palette entry under the pointer and then advances the pointer by one.
- R4: The pointer wraps from 255 to 0, so the 257th data write after a rewind overwrites entry 0.
- R5: A write with any other selector stores nothing, and wr_reject is high for exactly the cycle after it.
- R6: err_sticky sets in the cycle after a rejected write and holds until err_clr is applied. If a reject and err_clr arrive in the same cycle, the set wins.
- R7: A synchronous active-high reset clears all shadow registers, the palette pointer, wr_reject, err_sticky and both read outputs.
- R8: rd_sel carrying a code that is not an ordinary register (including 8'h00 and 8'h01) returns 0 on rd_shadow.
- R9: pal_rd_idx returns that palette entry on pal_rd_data one cycle later. A data write to the same entry in the same cycle returns the old contents.
- R10: While wr_en is low, wr_word has no effect on any register, the palette or the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for wr_word |
| wr_word | input | 32 | Selector [31:24] and payload [23:0] |
| err_clr | input | 1 | Clears the sticky error bit |
| rd_sel | input | 8 | Selector code of the shadow register to read |
| pal_rd_idx | input | 8 | Palette entry to read |
| rd_shadow | output | 24 | Shadow value, one cycle after rd_sel |
| pal_rd_data | output | 24 | Palette entry, one cycle after pal_rd_idx |
| wr_reject | output | 1 | One-cycle pulse after an unrecognised write |
| err_sticky | output | 1 | Sticky unrecognised-write flag |

## Verification
The checker watches the pointer on every cycle. It confirms that the pointer returns to zero after a rewind write and advances by exactly one, modulo 256, after each data write. It also confirms that the pointer holds still when no write is strobed, and it checks how the reject pulse and the sticky bit behave across set, hold and clear. Shadow contents, palette contents and the zero result for non-register read codes are beyond those local properties. Only the bench's reference model shows them: it fills the whole palette, wraps the pointer, rewinds part-way and reads every register back.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
    localparam int SEL_W      = 8;
    localparam int PAY_W      = 24;
    localparam int WORD_W     = SEL_W + PAY_W;
    localparam int PAL_DEPTH  = 256;
    localparam int NUM_CURSOR = 3;
    localparam int NUM_HTIM   = 6;
    localparam int NUM_VTIM   = 8;
    localparam int NUM_MISC   = 4;
    localparam int NUM_SHADOW = 1 + NUM_CURSOR + NUM_HTIM + NUM_VTIM + NUM_MISC;
    localparam int SH_IDX_W   = $clog2(NUM_SHADOW);

    localparam logic [SEL_W-1:0] SEL_PAL_REWIND = 8'h00;
    localparam logic [SEL_W-1:0] SEL_PAL_DATA   = 8'h01;
    localparam logic [SEL_W-1:0] SEL_BORDER     = 8'h10;
    localparam logic [SEL_W-1:0] SEL_CURSOR0    = 8'h11;
    localparam logic [SEL_W-1:0] SEL_HTIM0      = 8'h20;
    localparam logic [SEL_W-1:0] SEL_VTIM0      = 8'h30;
    localparam logic [SEL_W-1:0] SEL_MISC0      = 8'h40;

    localparam int IDX_CURSOR = 1;
    localparam int IDX_HTIM   = IDX_CURSOR + NUM_CURSOR;
    localparam int IDX_VTIM   = IDX_HTIM + NUM_HTIM;
    localparam int IDX_MISC   = IDX_VTIM + NUM_VTIM;

    typedef enum logic [1:0] {
        K_NONE,
        K_SHADOW,
        K_PAL_REWIND,
        K_PAL_DATA
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e             kind;
        logic [SH_IDX_W-1:0]   idx;
    } sel_dec_t;

    function automatic sel_dec_t in_group(logic [SEL_W-1:0] sel,
                                          logic [SEL_W-1:0] base,
                                          int count, int first_idx);
        sel_dec_t d;
        int off;
        off    = int'(sel) - int'(base);
        d.kind = K_NONE;
        d.idx  = '0;
        if (off >= 0 && off < count) begin
            d.kind = K_SHADOW;
            d.idx  = SH_IDX_W'(first_idx + off);
        end
        return d;
    endfunction

    function automatic sel_dec_t decode_sel(logic [SEL_W-1:0] sel);
        sel_dec_t d;
        d.kind = K_NONE;
        d.idx  = '0;
        if (sel == SEL_PAL_REWIND)     d.kind = K_PAL_REWIND;
        else if (sel == SEL_PAL_DATA)  d.kind = K_PAL_DATA;
        else if (sel == SEL_BORDER)    d.kind = K_SHADOW;
        else begin
            d = in_group(sel, SEL_CURSOR0, NUM_CURSOR, IDX_CURSOR);
            if (d.kind == K_NONE) d = in_group(sel, SEL_HTIM0, NUM_HTIM, IDX_HTIM);
            if (d.kind == K_NONE) d = in_group(sel, SEL_VTIM0, NUM_VTIM, IDX_VTIM);
            if (d.kind == K_NONE) d = in_group(sel, SEL_MISC0, NUM_MISC, IDX_MISC);
        end
        return d;
    endfunction
endpackage

// File: rtl/vreg_decode.sv
module vreg_decode
    import vreg_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output sel_dec_t         dec
);
    always_comb dec = decode_sel(sel);
endmodule

// File: rtl/vreg_shadow.sv
module vreg_shadow #(
    parameter int N = 22,
    parameter int W = 24,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic          rvalid,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) regs[widx] <= wdata;
            rdata <= rvalid ? regs[ridx] : '0;
        end
    end
endmodule

// File: rtl/vreg_palette.sv
module vreg_palette #(
    parameter int DEPTH = 256,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rewind,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ridx,
    output logic [W-1:0]  rdata,
    output logic [AW-1:0] ptr
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (push) mem[ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            rdata <= '0;
        end else begin
            rdata <= mem[ridx];
            if (rewind)    ptr <= '0;
            else if (push) ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/vreg_port.sv
module vreg_port
    import vreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              err_clr,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [7:0]        pal_rd_idx,
    output logic [PAY_W-1:0]  rd_shadow,
    output logic [PAY_W-1:0]  pal_rd_data,
    output logic              wr_reject,
    output logic              err_sticky
);
    localparam int PAL_AW = $clog2(PAL_DEPTH);

    sel_dec_t         wdec, rdec;
    logic [PAY_W-1:0] payload;
    logic             sh_we, pal_idx_wr, pal_data_wr, bad_wr;
    logic [PAL_AW-1:0] pal_ptr;

    assign payload = wr_word[PAY_W-1:0];

    vreg_decode u_wdec (.sel(wr_word[WORD_W-1:PAY_W]), .dec(wdec));
    vreg_decode u_rdec (.sel(rd_sel), .dec(rdec));

    always_comb begin
        sh_we       = wr_en && (wdec.kind == K_SHADOW);
        pal_idx_wr  = wr_en && (wdec.kind == K_PAL_REWIND);
        pal_data_wr = wr_en && (wdec.kind == K_PAL_DATA);
        bad_wr      = wr_en && (wdec.kind == K_NONE);
    end

    vreg_shadow #(.N(NUM_SHADOW), .W(PAY_W)) u_shadow (
        .clk(clk), .rst(rst),
        .we(sh_we), .widx(wdec.idx), .wdata(payload),
        .rvalid(rdec.kind == K_SHADOW), .ridx(rdec.idx),
        .rdata(rd_shadow)
    );

    vreg_palette #(.DEPTH(PAL_DEPTH), .W(PAY_W)) u_pal (
        .clk(clk), .rst(rst),
        .rewind(pal_idx_wr), .push(pal_data_wr), .wdata(payload),
        .ridx(pal_rd_idx[PAL_AW-1:0]),
        .rdata(pal_rd_data), .ptr(pal_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_reject  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            wr_reject <= bad_wr;
            if (bad_wr)       err_sticky <= 1'b1;
            else if (err_clr) err_sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/vreg_port_chk.sv
module vreg_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       err_clr,
    input logic       wr_reject,
    input logic       err_sticky,
    input logic [7:0] ptr,
    input logic       pal_idx_wr,
    input logic       pal_data_wr
);
    p_ptr_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(pal_idx_wr)) |-> (ptr == 8'd0));

    // R3 and R4: step of one, wrapping through the 8-bit width
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(pal_data_wr) && !$past(pal_idx_wr))
            |-> (ptr == 8'($past(ptr) + 8'd1)));

    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(pal_data_wr) && ($past(ptr) == 8'hFF))
            |-> (ptr == 8'd0));

    p_reject_src_r5: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> ($past(!rst) && $past(wr_en)));

    p_sticky_set_r6: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> err_sticky);

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(err_sticky) && !$past(err_clr)) |-> err_sticky);

    p_sticky_clear_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(err_clr) && !wr_reject) |-> !err_sticky);

    p_reset_r7: assert property (@(posedge clk)
        $past(rst) |-> (!err_sticky && !wr_reject && ptr == 8'd0));

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wr_en)) |-> ($stable(ptr) && !wr_reject));
endmodule

bind vreg_port vreg_port_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .err_clr(err_clr),
    .wr_reject(wr_reject), .err_sticky(err_sticky), .ptr(pal_ptr),
    .pal_idx_wr(pal_idx_wr), .pal_data_wr(pal_data_wr)
);

// File: tb/tb_vreg_port.sv
module tb_vreg_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        err_clr = 1'b0;
    logic [7:0]  rd_sel = '0;
    logic [7:0]  pal_rd_idx = '0;
    logic [23:0] rd_shadow, pal_rd_data;
    logic        wr_reject, err_sticky;

    always #4 clk = ~clk;

    vreg_port dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word),
        .err_clr(err_clr), .rd_sel(rd_sel), .pal_rd_idx(pal_rd_idx),
        .rd_shadow(rd_shadow), .pal_rd_data(pal_rd_data),
        .wr_reject(wr_reject), .err_sticky(err_sticky)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string req = "R7";

    // reference state
    logic [23:0] m_sh [byte unsigned];
    logic [23:0] m_pal [256];
    bit          m_pal_ok [256];
    int          m_ptr = 0;
    bit          m_sticky = 0;
    logic [23:0] e_sh = '0, e_pal = '0;
    bit          e_rej = 0, e_pal_ok = 1;

    function automatic bit is_reg(byte unsigned s);
        return s == 8'h10 || (s >= 8'h11 && s <= 8'h13) || (s >= 8'h20 && s <= 8'h25)
            || (s >= 8'h30 && s <= 8'h37) || (s >= 8'h40 && s <= 8'h43);
    endfunction

    task automatic cmp(string what, logic [23:0] got, logic [23:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL [%s] %s got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        cmp("rd_shadow", rd_shadow, e_sh);
        if (e_pal_ok) cmp("pal_rd_data", pal_rd_data, e_pal);
        cmp("wr_reject", {23'd0, wr_reject}, {23'd0, e_rej});
        cmp("err_sticky", {23'd0, err_sticky}, {23'd0, m_sticky});
    endtask

    task automatic cyc(bit r, bit we, logic [31:0] w, bit clr, byte unsigned rs, byte unsigned pi);
        byte unsigned s;
        rst = r; wr_en = we; wr_word = w; err_clr = clr; rd_sel = rs; pal_rd_idx = pi;
        s = w[31:24];
        if (r) begin
            m_sh.delete(); m_ptr = 0; m_sticky = 0;
            e_sh = '0; e_pal = '0; e_pal_ok = 1; e_rej = 0;
        end else begin
            e_sh = (is_reg(rs) && m_sh.exists(rs)) ? m_sh[rs] : 24'd0;
            e_pal = m_pal[pi]; e_pal_ok = m_pal_ok[pi];
            e_rej = 0;
            if (we) begin
                if (s == 8'h00) m_ptr = 0;
                else if (s == 8'h01) begin
                    m_pal[m_ptr] = w[23:0]; m_pal_ok[m_ptr] = 1;
                    m_ptr = (m_ptr + 1) % 256;
                end else if (is_reg(s)) m_sh[s] = w[23:0];
                else e_rej = 1;
            end
            if (e_rej) m_sticky = 1;
            else if (clr) m_sticky = 0;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [31:0] w);
        cyc(0, 1, w, 0, 8'h00, 8'h00);
    endtask

    task automatic idle(byte unsigned rs, byte unsigned pi);
        cyc(0, 0, 32'h0, 0, rs, pi);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) m_pal_ok[i] = 0;
        @(negedge clk);
        req = "R7";
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);

        // R1: every ordinary register, then read back
        req = "R1";
        for (int s = 0; s < 256; s++)
            if (is_reg(byte'(s))) wr({8'(s), 24'(32'h5A0000 ^ (s * 32'h10101))});
        for (int s = 0; s < 256; s++)
            if (is_reg(byte'(s))) idle(byte'(s), 0);
        idle(8'h10, 0);

        // R8: non-register read codes give zero
        req = "R8";
        idle(8'h00, 0); idle(8'h01, 0); idle(8'h14, 0); idle(8'hFF, 0); idle(8'h44, 0);

        // R5 / R6: rejected writes and sticky behaviour
        req = "R5";
        wr(32'h02_123456); idle(0, 0); wr(32'hFF_ABCDEF); wr(32'h26_000001);
        idle(8'h25, 0);
        req = "R6";
        idle(0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        idle(0, 0);
        wr(32'h38_000000);
        cyc(0, 1, 32'h14_777777, 1, 8'h13, 0); // clear and reject together: set wins
        cyc(0, 0, 0, 1, 8'h14, 0);
        idle(0, 0);

        // R3 / R4: fill all entries, then wrap
        req = "R3";
        wr(32'h00_FFFFFF);
        for (int i = 0; i < 256; i++) wr({8'h01, 24'(i * 32'h010203 + 32'h40)});
        req = "R4";
        wr(32'h01_C0FFEE); wr(32'h01_BADA55);
        for (int i = 0; i < 4; i++) idle(0, byte'(i));
        idle(0, 8'hFF);

        // R2: rewind part-way with nonzero payload
        req = "R2";
        for (int i = 0; i < 10; i++) wr({8'h01, 24'(32'h900000 + i)});
        wr(32'h00_00AB12);
        wr(32'h01_111111);
        idle(0, 0); idle(0, 1); idle(0, 11);

        // R9: read and write same entry in the same cycle
        req = "R9";
        cyc(0, 1, 32'h01_222222, 0, 0, 8'h01);
        idle(0, 8'h01);
        for (int i = 0; i < 256; i += 17) idle(0, byte'(i));

        // R10: garbage with strobe low
        req = "R10";
        cyc(0, 0, 32'h01_DEAD00, 0, 8'h10, 8'h02);
        cyc(0, 0, 32'h10_DEAD01, 0, 8'h10, 8'h02);
        cyc(0, 0, 32'hEE_DEAD02, 0, 8'h10, 8'h02);
        wr(32'h01_333333);
        idle(0, 8'h02); idle(0, 8'h03);

        // R7: reset mid-run
        req = "R7";
        wr(32'h99_000000);
        cyc(1, 0, 0, 0, 8'h10, 0);
        idle(8'h10, 0); idle(8'h37, 0);
        wr(32'h01_444444);
        idle(0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL [watchdog] run got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule